// File: doc/BRIEF.md
# Multicast Hash Address Filter

This block decides whether a received destination MAC address passes a 64-bit multicast hash filter. The address is reduced to a 6-bit index with the Ethernet CRC32. The index picks one bit of a table held in two 32-bit words. A group address is accepted when its bit is set. A host port lets software clear the table, write either word and read either word back, so that it can add an address by read-modify-write.

The receive side takes a 48-bit address with a one-cycle strobe. It feeds one address byte per clock through a reflected CRC32 engine. It then returns a one-cycle result pulse carrying the computed index and the accept decision. Individual (non-group) addresses are not filtered here. For them the decision is always "pass", which leaves unicast and broadcast matching to other logic.

Top module: `mcast_hash_filter`

## Requirements
- R1: After reset both table words read as zero, and `busy` and `res_valid` are low.
- R2: The CRC uses the reflected polynomial 0xEDB88320 with an initial value of all ones. It consumes the address bytes in the order `rx_addr[47:40]` first down to `rx_addr[7:0]` last, each byte least significant bit first, with no final inversion at this stage.
- R3: The hash value is the complemented CRC, bit-reversed across 32 bits. `res_index[5]` is hash bit 31 and selects the table word (0 or 1). `res_index[4:0]` is hash bits 30..26 and selects the bit within that word.
- R4: A strobe accepted at clock edge N produces `res_valid` high for exactly one cycle, after edge N+7. `busy` is high from edge N up to edge N+7.
- R5: For a group address (`rx_addr[40]` = 1), `res_hit` equals the table bit at word `res_index[5]`, bit `res_index[4:0]`.
- R6: For an individual address (`rx_addr[40]` = 0), `res_hit` is 1 whatever the table holds.
- R7: `hst_wr` writes `hst_wdata` into word `hst_sel` at the next edge and leaves the other word unchanged. `hst_rdata` shows word `hst_sel` combinationally.
- R8: `hst_clr` zeroes both words at the next edge and takes priority over a write in the same cycle.
- R9: A strobe that arrives while `busy` is high is ignored. It changes neither the pending result nor the number of result pulses.
- R10: The decision uses the table contents as they stand before edge N+7. A write or clear at an earlier edge is seen, and one landing on edge N+7 itself is not.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| hst_wr | input | 1 | Host write enable for the selected word |
| hst_clr | input | 1 | Host clear of both table words |
| hst_sel | input | 1 | Host word select (0 or 1) |
| hst_wdata | input | 32 | Host write data |
| hst_rdata | output | 32 | Selected table word |
| rx_valid | input | 1 | Address strobe |
| rx_addr | input | 48 | Destination address, first wire byte in bits 47:40 |
| busy | output | 1 | Hash in progress |
| res_valid | output | 1 | One-cycle result pulse |
| res_hit | output | 1 | Accept decision |
| res_index | output | 6 | Computed hash index {word, bit} |

## Verification
A host table update and the latching of a lookup decision can fall on the same clock edge. This is the one place where the two sides of the block interact. The bench provokes it by timing a write one edge before the result edge and a clear exactly on the result edge. It then judges that the earlier write is honoured, that the coincident clear is not, and that the clear has still taken effect when the table is read back afterwards. A second overlap is a new strobe landing mid-hash, and the bench judges it by the index of the only result pulse that appears.

// File: rtl/mcast_hash_filter.sv
module mcast_hash_filter #(
  parameter int          ADDR_BYTES = 6,
  parameter logic [31:0] POLY_REFL  = 32'hEDB88320
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    hst_wr,
  input  logic                    hst_clr,
  input  logic                    hst_sel,
  input  logic [31:0]             hst_wdata,
  output logic [31:0]             hst_rdata,
  input  logic                    rx_valid,
  input  logic [8*ADDR_BYTES-1:0] rx_addr,
  output logic                    busy,
  output logic                    res_valid,
  output logic                    res_hit,
  output logic [5:0]              res_index
);
  localparam int AW = 8 * ADDR_BYTES;
  localparam int CW = $clog2(ADDR_BYTES + 1);

  logic [1:0][31:0] tbl_q;
  logic [AW-1:0]    addr_q;
  logic [31:0]      crc_q;
  logic [31:0]      hash;
  logic [CW-1:0]    cnt_q;
  logic             busy_q, mc_q;
  logic             res_valid_q, res_hit_q;
  logic [5:0]       res_index_q;
  logic [5:0]       idx;

  function automatic logic [31:0] crc_byte(input logic [31:0] c, input logic [7:0] b);
    logic [31:0] r;
    r = c;
    for (int i = 0; i < 8; i++) begin
      if (r[0] ^ b[i]) r = (r >> 1) ^ POLY_REFL;
      else             r = r >> 1;
    end
    return r;
  endfunction

  for (genvar i = 0; i < 32; i++) begin : g_rev
    assign hash[i] = ~crc_q[31-i];
  end
  assign idx = hash[31:26];

  always_ff @(posedge clk) begin
    if (!rst_n) tbl_q <= '0;
    else if (hst_clr) tbl_q <= '0;
    else if (hst_wr) tbl_q[hst_sel] <= hst_wdata;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      addr_q      <= '0;
      crc_q       <= '1;
      cnt_q       <= '0;
      busy_q      <= 1'b0;
      mc_q        <= 1'b0;
      res_valid_q <= 1'b0;
      res_hit_q   <= 1'b0;
      res_index_q <= '0;
    end else begin
      res_valid_q <= 1'b0;
      if (!busy_q) begin
        if (rx_valid) begin
          addr_q <= rx_addr;
          crc_q  <= '1;
          cnt_q  <= '0;
          busy_q <= 1'b1;
          mc_q   <= rx_addr[AW-8];
        end
      end else if (cnt_q == CW'(ADDR_BYTES)) begin
        busy_q      <= 1'b0;
        res_valid_q <= 1'b1;
        res_index_q <= idx;
        res_hit_q   <= !mc_q || tbl_q[idx[5]][idx[4:0]];
      end else begin
        crc_q  <= crc_byte(crc_q, addr_q[AW-1 -: 8]);
        addr_q <= addr_q << 8;
        cnt_q  <= cnt_q + 1'b1;
      end
    end
  end

  assign hst_rdata = tbl_q[hst_sel];
  assign busy      = busy_q;
  assign res_valid = res_valid_q;
  assign res_hit   = res_hit_q;
  assign res_index = res_index_q;
endmodule

// File: rtl/mcast_hash_filter_chk.sv
module mcast_hash_filter_chk (
  input logic             clk,
  input logic             rst_n,
  input logic             hst_wr,
  input logic             hst_clr,
  input logic             hst_sel,
  input logic [31:0]      hst_wdata,
  input logic             rx_valid,
  input logic             busy,
  input logic             res_valid,
  input logic             res_hit,
  input logic             mc,
  input logic [1:0][31:0] tbl
);
  // R4
  res_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |=> !res_valid);

  // R4
  res_after_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> ($past(busy) && !busy));

  // R9
  busy_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid && !busy) |=> busy);

  // R6
  unicast_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && !mc) |-> res_hit);

  // R8
  clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hst_clr |=> (tbl == '0));

  // R7
  write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (hst_wr && !hst_clr) |=> (tbl[$past(hst_sel)] == $past(hst_wdata)));

  // R7
  write_other_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (hst_wr && !hst_clr) |=> (tbl[!$past(hst_sel)] == $past(tbl[!hst_sel])));
endmodule

bind mcast_hash_filter mcast_hash_filter_chk u_chk (
  .clk(clk), .rst_n(rst_n), .hst_wr(hst_wr), .hst_clr(hst_clr),
  .hst_sel(hst_sel), .hst_wdata(hst_wdata), .rx_valid(rx_valid),
  .busy(busy), .res_valid(res_valid), .res_hit(res_hit),
  .mc(mc_q), .tbl(tbl_q)
);

// File: tb/test_mcast_hash_filter.sv
module test_mcast_hash_filter;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        hst_wr = 1'b0, hst_clr = 1'b0, hst_sel = 1'b0;
  logic [31:0] hst_wdata = '0;
  logic [31:0] hst_rdata;
  logic        rx_valid = 1'b0;
  logic [47:0] rx_addr = '0;
  logic        busy, res_valid, res_hit;
  logic [5:0]  res_index;

  int checks = 0;
  int failures = 0;

  always #2 clk = ~clk;

  mcast_hash_filter i_mcast_hash_filter (
    .clk(clk), .rst_n(rst_n), .hst_wr(hst_wr), .hst_clr(hst_clr),
    .hst_sel(hst_sel), .hst_wdata(hst_wdata), .hst_rdata(hst_rdata),
    .rx_valid(rx_valid), .rx_addr(rx_addr), .busy(busy),
    .res_valid(res_valid), .res_hit(res_hit), .res_index(res_index)
  );

  task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [5:0] model_index(input logic [47:0] a);
    logic [31:0] c;
    logic [7:0]  b;
    logic [31:0] h;
    c = 32'hFFFF_FFFF;
    for (int k = 0; k < 6; k++) begin
      b = a[47-8*k -: 8];
      for (int i = 0; i < 8; i++) begin
        if (c[0] ^ b[i]) c = (c >> 1) ^ 32'hEDB88320;
        else             c = c >> 1;
      end
    end
    c = ~c;
    for (int i = 0; i < 32; i++) h[31-i] = c[i];
    return h[31:26];
  endfunction

  task automatic host_write(input logic sel, input logic [31:0] d);
    @(negedge clk); hst_wr = 1'b1; hst_sel = sel; hst_wdata = d;
    @(negedge clk); hst_wr = 1'b0;
  endtask

  task automatic host_clear();
    @(negedge clk); hst_clr = 1'b1;
    @(negedge clk); hst_clr = 1'b0;
  endtask

  task automatic start(input logic [47:0] a);
    @(negedge clk); rx_valid = 1'b1; rx_addr = a;
    @(negedge clk); rx_valid = 1'b0;
  endtask

  task automatic finish_lookup(output logic hit, output logic [5:0] idx);
    repeat (6) @(negedge clk);
    check(!res_valid && busy, "R4 early", {res_valid, busy}, 2'b01);
    @(negedge clk);
    check(res_valid && !busy, "R4 result edge", {res_valid, busy}, 2'b10);
    hit = res_hit;
    idx = res_index;
    @(negedge clk);
    check(!res_valid, "R4 single pulse", res_valid, 0);
  endtask

  function automatic logic [47:0] find_addr(input logic [5:0] k, input logic [47:0] base);
    logic [47:0] a;
    a = base;
    for (int j = 0; j < 8192; j++) begin
      a = base + 48'(j);
      if (model_index(a) == k) return a;
    end
    return base;
  endfunction

  initial begin
    #(4 * 150000);
    failures++;
    $display("FAIL R4 watchdog actual=hung expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    logic        hit;
    logic [5:0]  idx;
    logic [47:0] a;
    logic [47:0] lcg;
    logic [31:0] p0, p1;
    logic [5:0]  e;

    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    hst_sel = 1'b0; #1;
    check(hst_rdata == 0, "R1 word0", hst_rdata, 0);
    hst_sel = 1'b1; #1;
    check(hst_rdata == 0, "R1 word1", hst_rdata, 0);
    check(!busy && !res_valid, "R1 flags", {busy, res_valid}, 0);

    // R7 write and read back, other word untouched
    host_write(1'b0, 32'hDEAD_BEEF);
    host_write(1'b1, 32'h1234_5678);
    hst_sel = 1'b0; #1;
    check(hst_rdata == 32'hDEAD_BEEF, "R7 word0", hst_rdata, 32'hDEAD_BEEF);
    hst_sel = 1'b1; #1;
    check(hst_rdata == 32'h1234_5678, "R7 word1", hst_rdata, 32'h1234_5678);

    // R8 clear wins over simultaneous write
    @(negedge clk); hst_clr = 1'b1; hst_wr = 1'b1; hst_sel = 1'b0; hst_wdata = 32'hFFFF_FFFF;
    @(negedge clk); hst_clr = 1'b0; hst_wr = 1'b0;
    hst_sel = 1'b0; #1;
    check(hst_rdata == 0, "R8 word0", hst_rdata, 0);
    hst_sel = 1'b1; #1;
    check(hst_rdata == 0, "R8 word1", hst_rdata, 0);

    // R2 R3 R5 sweep of every index
    for (int k = 0; k < 64; k++) begin
      a = find_addr(6'(k), 48'h0100_5E00_0000 + 48'(k * 4096));
      check(model_index(a) == 6'(k), "R3 search", model_index(a), k);
      host_clear();
      host_write(k[5], 32'h1 << k[4:0]);
      start(a);
      finish_lookup(hit, idx);
      check(idx == 6'(k), "R2 R3 index", idx, k);
      check(hit == 1'b1, "R5 hit set bit", hit, 1);
      host_write(k[5], ~(32'h1 << k[4:0]));
      host_write(!k[5], 32'hFFFF_FFFF);
      start(a);
      finish_lookup(hit, idx);
      check(hit == 1'b0, "R5 miss clear bit", hit, 0);
    end

    // R5 R6 patterned table with varied addresses
    p0 = 32'hA5C3_0F96;
    p1 = 32'h3C5A_F00F;
    host_write(1'b0, p0);
    host_write(1'b1, p1);
    lcg = 48'h1357_9BDF_2468;
    for (int n = 0; n < 40; n++) begin
      lcg = lcg * 48'd25214903917 + 48'd11;
      a = lcg;
      a[40] = n[0];
      e = model_index(a);
      start(a);
      finish_lookup(hit, idx);
      check(idx == e, "R2 index pattern", idx, e);
      if (a[40]) check(hit == (e[5] ? p1[e[4:0]] : p0[e[4:0]]), "R5 pattern", hit, e[5] ? p1[e[4:0]] : p0[e[4:0]]);
      else       check(hit == 1'b1, "R6 individual pass", hit, 1);
    end

    // R6 individual address with empty table
    host_clear();
    start(48'h0000_1122_3344);
    finish_lookup(hit, idx);
    check(hit == 1'b1, "R6 empty table", hit, 1);

    // R9 strobe while busy ignored
    a = 48'h0100_5E7F_0001;
    start(a);
    repeat (2) @(negedge clk);
    rx_valid = 1'b1; rx_addr = 48'h3300_0000_0001;
    @(negedge clk); rx_valid = 1'b0;
    repeat (3) @(negedge clk);
    check(!res_valid, "R9 no early result", res_valid, 0);
    @(negedge clk);
    check(res_valid && res_index == model_index(a), "R9 first address kept", res_index, model_index(a));
    repeat (8) begin
      @(negedge clk);
      check(!res_valid && !busy, "R9 no second pulse", {res_valid, busy}, 0);
    end

    // R10 write one edge early is seen, clear on the result edge is not
    a = find_addr(6'd37, 48'h0100_5E00_4000);
    host_clear();
    start(a);
    repeat (5) @(negedge clk);
    hst_wr = 1'b1; hst_sel = 1'b1; hst_wdata = 32'h0000_0020;
    @(negedge clk); hst_wr = 1'b0; hst_clr = 1'b1;
    @(negedge clk); hst_clr = 1'b0;
    check(res_valid && res_hit, "R10 early write seen", {res_valid, res_hit}, 2'b11);
    hst_sel = 1'b1; #1;
    check(hst_rdata == 0, "R10 clear applied", hst_rdata, 0);

    // R10 write landing on the result edge is not seen
    start(a);
    repeat (6) @(negedge clk);
    hst_wr = 1'b1; hst_sel = 1'b1; hst_wdata = 32'h0000_0020;
    @(negedge clk); hst_wr = 1'b0;
    check(res_valid && !res_hit, "R10 coincident write unseen", {res_valid, res_hit}, 2'b10);
    #1;
    check(hst_rdata == 32'h20, "R10 coincident write stored", hst_rdata, 32'h20);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule